// File: doc/BRIEF.md
# Lockable Encryption Region Configuration Bank

This block holds the per-region settings that an inline memory encryption engine needs, for eight independent regions. Each region keeps an attribute word (bypass flag, cipher mode, key size), two key registers of eight 32-bit words each, and a page-offset register. A simple write port updates these registers. A combinational read port returns their contents, except that key registers always read as zero.

A global configuration word gives each region a sticky write lock and provides a self-clearing soft reset. Software can set a lock but cannot clear it. Only the system reset clears the locks. The soft reset wipes every region's attributes and keys. It leaves page offsets and locks untouched.

The downstream cipher datapath presents a region index. The bank returns that region's decoded settings combinationally: the mode, the key width, both keys, the page offset, and a single pass-through flag.

Top module: `enc_region_bank`

## Requirements
- R1: After system reset every region has bypass 0, mode 0 (none), key size 0, offset 0 and all-zero keys, and the global word reads 0.
- R2: An attribute write to word address 0x100 + 0x20*n + 0 stores mode from data bits [2:0], key size from bit 4 and bypass from bit 7. A read of the same address returns only those bits, with every other bit zero.
- R3: A write to sub-address 1 of a region stores the page offset (a count of 4 KiB pages) from data bits [19:0]. A read returns it zero-extended.
- R4: Sub-addresses 8..15 write word 0..7 of the first key and 16..23 write word 0..7 of the second key. Word i appears at bits [32i+31:32i] of the key output. Reads of key addresses return 0.
- R5: The pass-through flag is 1 when bypass is 1, when mode is 0 (none), or when mode is a reserved value 5..7. It is 0 for mode 1 (XTS), 2 (counter with address binding), 3 (counter without address binding) and 4 (keystream only) with bypass 0.
- R6: The selected-region outputs follow the region index combinationally.
- R7: Writing a 1 to bit n of the global word (address 0) locks region n. Writing 0 does not unlock. Only the system reset clears a lock.
- R8: A write to any register of a locked region leaves it unchanged. The write-error output is then 1 for exactly the one cycle after the write.
- R9: Writing bit 31 of the global word reads back as 1 for one cycle. On the next edge all attributes and keys are zeroed, while offsets and locks are kept. Lock bits in the same write still take effect, and the wipe wins over a write in the same cycle.
- R10: A write to an unlocked region never raises the write-error output. Writes to unused sub-addresses (2..7, 24..31) change nothing and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 9 | Word address of the write |
| wrData | input | 32 | Write data |
| wrErr | output | 1 | One-cycle flag: previous write hit a locked region |
| rdAddr | input | 9 | Word address of the read |
| rdData | output | 32 | Read data (keys read as zero) |
| selRegion | input | 3 | Region index from the cipher datapath |
| selBypass | output | 1 | Stored bypass bit of the selected region |
| selMode | output | 3 | Stored mode of the selected region |
| selKeyWide | output | 1 | Stored key-size bit of the selected region |
| selPass | output | 1 | Decoded pass-through flag of the selected region |
| selOffset | output | 20 | Page offset of the selected region |
| selKey1 | output | 256 | First key of the selected region |
| selKey2 | output | 256 | Second key of the selected region |

## Verification
Several properties are checked on every cycle. Locks never fall while reset is inactive. The soft-reset request lasts one cycle. A write-error pulse is always preceded by a write. The selected region's settings stay frozen while it is locked, and a wipe leaves the selected region's attributes and keys at zero. The bench scenarios are the only place where field positions, offset truncation, key word placement, the pass-through decode of every mode class, and the read-as-zero rules are shown. They also cover locks set together with a soft reset and lock clearing by system reset.

// File: rtl/encbank_pkg.sv
package encbank_pkg;
  localparam int REGION_CNT = 8;
  localparam int REGION_W   = $clog2(REGION_CNT);
  localparam int DATA_W     = 32;
  localparam int KEY_WORDS  = 8;
  localparam int WORD_W     = $clog2(KEY_WORDS);
  localparam int KEY_W      = KEY_WORDS * DATA_W;
  localparam int PAGE_SHIFT = 12;
  localparam int OFFSET_W   = DATA_W - PAGE_SHIFT;
  localparam int SUB_W      = WORD_W + 2;
  localparam int ADDR_W     = 1 + REGION_W + SUB_W;

  // sub-address map inside a region block
  localparam logic [SUB_W-1:0] SUB_ATTR   = SUB_W'(0);
  localparam logic [SUB_W-1:0] SUB_OFFSET = SUB_W'(1);
  localparam logic [1:0]       KEY1_SEL   = 2'b01;
  localparam logic [1:0]       KEY2_SEL   = 2'b10;

  // attribute word field positions
  localparam int MODE_LSB   = 0;
  localparam int MODE_W     = 3;
  localparam int KSIZE_BIT  = 4;
  localparam int BYPASS_BIT = 7;
  localparam int SRST_BIT   = DATA_W - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_NONE       = 3'd0,
    MODE_XTS        = 3'd1,
    MODE_CTR_ADDR   = 3'd2,
    MODE_CTR_PLAIN  = 3'd3,
    MODE_CTR_STREAM = 3'd4
  } cipherMode_e;

  typedef struct packed {
    logic              bypass;
    logic              keyWide;
    logic [MODE_W-1:0] mode;
  } regionAttr_t;

  typedef struct packed {
    logic                wipe;
    logic                attrWe;
    logic                offWe;
    logic                keyWe;
    logic                keySecond;
    logic [REGION_W-1:0] region;
    logic [WORD_W-1:0]   word;
  } bankStrobe_t;
endpackage

// File: rtl/encbank_ctrl.sv
module encbank_ctrl
  import encbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REGION_CNT-1:0] gcfgLocks,
  input  logic                  gcfgSrst,
  output bankStrobe_t           strb,
  output logic [REGION_CNT-1:0] lockVec,
  output logic                  wipePend,
  output logic                  wrErr
);
  logic                inRegion;
  logic                isGcfg;
  logic [REGION_W-1:0] region;
  logic [SUB_W-1:0]    sub;
  logic                hit;
  logic                allowed;
  logic [1:0]          keyBank;

  assign inRegion = wrAddr[ADDR_W-1];
  assign isGcfg   = !wrAddr[ADDR_W-1] && (wrAddr[ADDR_W-2:0] == '0);
  assign region   = wrAddr[SUB_W +: REGION_W];
  assign sub      = wrAddr[SUB_W-1:0];
  assign keyBank  = sub[SUB_W-1 -: 2];
  assign hit      = wrEn && inRegion;
  assign allowed  = hit && !lockVec[region];

  always_comb begin
    strb           = '0;
    strb.wipe      = wipePend;
    strb.region    = region;
    strb.word      = sub[WORD_W-1:0];
    strb.keySecond = (keyBank == KEY2_SEL);
    strb.attrWe    = allowed && (sub == SUB_ATTR);
    strb.offWe     = allowed && (sub == SUB_OFFSET);
    strb.keyWe     = allowed && ((keyBank == KEY1_SEL) || (keyBank == KEY2_SEL));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockVec  <= '0;
      wipePend <= 1'b0;
      wrErr    <= 1'b0;
    end else begin
      if (wrEn && isGcfg) lockVec <= lockVec | gcfgLocks;
      wipePend <= wrEn && isGcfg && gcfgSrst && !wipePend;
      wrErr    <= hit && lockVec[region];
    end
  end

  // R7: locks are sticky while system reset is inactive
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockVec != '0) |=> ((lockVec & $past(lockVec)) == $past(lockVec)));

  // R9: the soft reset request lasts one cycle
  p_srst_selfclear_r9: assert property (@(posedge clk) disable iff (!rstN)
    wipePend |=> !wipePend);

  // R8: an error pulse always follows a write
  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn));
endmodule

// File: rtl/encbank_store.sv
module encbank_store
  import encbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [REGION_CNT-1:0] lockVec,
  input  logic                  wipePend,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  logic [REGION_W-1:0]   selRegion,
  output logic                  selBypass,
  output logic [MODE_W-1:0]     selMode,
  output logic                  selKeyWide,
  output logic                  selPass,
  output logic [OFFSET_W-1:0]   selOffset,
  output logic [KEY_W-1:0]      selKey1,
  output logic [KEY_W-1:0]      selKey2
);
  regionAttr_t       attrQ [REGION_CNT];
  logic [OFFSET_W-1:0] offQ [REGION_CNT];
  logic [DATA_W-1:0] key1Q [REGION_CNT][KEY_WORDS];
  logic [DATA_W-1:0] key2Q [REGION_CNT][KEY_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REGION_CNT; r++) begin
        attrQ[r] <= '0;
        offQ[r]  <= '0;
        for (int w = 0; w < KEY_WORDS; w++) begin
          key1Q[r][w] <= '0;
          key2Q[r][w] <= '0;
        end
      end
    end else if (strb.wipe) begin
      for (int r = 0; r < REGION_CNT; r++) begin
        attrQ[r] <= '0;
        for (int w = 0; w < KEY_WORDS; w++) begin
          key1Q[r][w] <= '0;
          key2Q[r][w] <= '0;
        end
      end
    end else begin
      if (strb.attrWe) begin
        attrQ[strb.region].mode    <= wrData[MODE_LSB +: MODE_W];
        attrQ[strb.region].keyWide <= wrData[KSIZE_BIT];
        attrQ[strb.region].bypass  <= wrData[BYPASS_BIT];
      end
      if (strb.offWe) offQ[strb.region] <= wrData[OFFSET_W-1:0];
      if (strb.keyWe) begin
        if (strb.keySecond) key2Q[strb.region][strb.word] <= wrData;
        else                key1Q[strb.region][strb.word] <= wrData;
      end
    end
  end

  // read port
  logic                rdInRegion;
  logic                rdGcfg;
  logic [REGION_W-1:0] rdRegion;
  logic [SUB_W-1:0]    rdSub;
  assign rdInRegion = rdAddr[ADDR_W-1];
  assign rdGcfg     = !rdAddr[ADDR_W-1] && (rdAddr[ADDR_W-2:0] == '0);
  assign rdRegion   = rdAddr[SUB_W +: REGION_W];
  assign rdSub      = rdAddr[SUB_W-1:0];

  always_comb begin
    rdData = '0;
    if (rdGcfg) begin
      rdData[REGION_CNT-1:0] = lockVec;
      rdData[SRST_BIT]       = wipePend;
    end else if (rdInRegion && rdSub == SUB_ATTR) begin
      rdData[MODE_LSB +: MODE_W] = attrQ[rdRegion].mode;
      rdData[KSIZE_BIT]          = attrQ[rdRegion].keyWide;
      rdData[BYPASS_BIT]         = attrQ[rdRegion].bypass;
    end else if (rdInRegion && rdSub == SUB_OFFSET) begin
      rdData[OFFSET_W-1:0] = offQ[rdRegion];
    end
  end

  // selected-region view for the cipher datapath
  assign selBypass  = attrQ[selRegion].bypass;
  assign selMode    = attrQ[selRegion].mode;
  assign selKeyWide = attrQ[selRegion].keyWide;
  assign selOffset  = offQ[selRegion];
  assign selPass    = selBypass || (selMode == MODE_NONE) || (selMode > MODE_CTR_STREAM);

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_keyFlat
    assign selKey1[w*DATA_W +: DATA_W] = key1Q[selRegion][w];
    assign selKey2[w*DATA_W +: DATA_W] = key2Q[selRegion][w];
  end

  // R9: a wipe leaves attributes and keys zero
  p_wipe_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (selMode == '0 && !selBypass && !selKeyWide &&
                   selKey1 == '0 && selKey2 == '0));

  // R8: a locked selected region keeps its settings unless wiped
  p_locked_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lockVec[selRegion] && !strb.wipe) |=>
      (selRegion != $past(selRegion)) ||
      $stable({selBypass, selMode, selKeyWide, selOffset, selKey1, selKey2}));
endmodule

// File: rtl/enc_region_bank.sv
module enc_region_bank
  import encbank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wrErr,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [REGION_W-1:0] selRegion,
  output logic                selBypass,
  output logic [MODE_W-1:0]   selMode,
  output logic                selKeyWide,
  output logic                selPass,
  output logic [OFFSET_W-1:0] selOffset,
  output logic [KEY_W-1:0]    selKey1,
  output logic [KEY_W-1:0]    selKey2
);
  bankStrobe_t           strb;
  logic [REGION_CNT-1:0] lockVec;
  logic                  wipePend;

  encbank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .gcfgLocks (wrData[REGION_CNT-1:0]),
    .gcfgSrst  (wrData[SRST_BIT]),
    .strb      (strb),
    .lockVec   (lockVec),
    .wipePend  (wipePend),
    .wrErr     (wrErr)
  );

  encbank_store u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .lockVec    (lockVec),
    .wipePend   (wipePend),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .selRegion  (selRegion),
    .selBypass  (selBypass),
    .selMode    (selMode),
    .selKeyWide (selKeyWide),
    .selPass    (selPass),
    .selOffset  (selOffset),
    .selKey1    (selKey1),
    .selKey2    (selKey2)
  );
endmodule

// File: tb/enc_region_bank_tb.sv
`timescale 1ns/1ps
module enc_region_bank_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [8:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         wrErr;
  logic [8:0]   rdAddr = '0;
  logic [31:0]  rdData;
  logic [2:0]   selRegion = '0;
  logic         selBypass, selKeyWide, selPass;
  logic [2:0]   selMode;
  logic [19:0]  selOffset;
  logic [255:0] selKey1, selKey2;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  enc_region_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrErr(wrErr), .rdAddr(rdAddr), .rdData(rdData), .selRegion(selRegion),
    .selBypass(selBypass), .selMode(selMode), .selKeyWide(selKeyWide),
    .selPass(selPass), .selOffset(selOffset), .selKey1(selKey1), .selKey2(selKey2)
  );

  // {address, write data, expected read-back}
  localparam int NVEC = 8;
  localparam logic [72:0] VEC [NVEC] = '{
    {9'h100, 32'hFFFF_FF92, 32'h0000_0092},  // R2 r0 mode2 wide bypass
    {9'h160, 32'h0000_0011, 32'h0000_0011},  // R2 r3 XTS wide
    {9'h1E0, 32'h0000_0004, 32'h0000_0004},  // R2 r7 keystream
    {9'h161, 32'hFFFF_FFFF, 32'h000F_FFFF},  // R3 r3 offset truncated
    {9'h1A1, 32'h0001_2345, 32'h0001_2345},  // R3 r5 offset
    {9'h168, 32'hA5A5_A5A5, 32'h0000_0000},  // R4 r3 key1 word0
    {9'h177, 32'h5A5A_0001, 32'h0000_0000},  // R4 r3 key2 word7
    {9'h1C2, 32'h0000_FFFF, 32'h0000_0000}   // R10 reserved sub-address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [8:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic pick(input logic [2:0] r);
    selRegion = r;
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset defaults
    doRead(9'h000, rv); chk("R1 global", rv, 32'h0);
    for (int r = 0; r < 8; r++) begin
      pick(3'(r));
      chk("R1 region defaults",
          {selBypass, selMode, selKeyWide, selPass, selOffset, 4'h0},
          {1'b0, 3'd0, 1'b0, 1'b1, 20'h0, 4'h0});
      chk("R1 key zero", {31'h0, (selKey1 == '0 && selKey2 == '0)}, 32'h1);
    end

    // table walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC[i][72:64], VEC[i][63:32]);
      doRead(VEC[i][72:64], rv);
      chk("R2/R3/R4/R10 readback", rv, VEC[i][31:0]);
      chk("R10 no error unlocked", {31'h0, wrErr}, 32'h0);
    end

    // R6 / R4 / R5 selected view
    pick(3'd3);
    chk("R6 mode r3", {29'h0, selMode}, 32'h1);
    chk("R6 keyWide r3", {31'h0, selKeyWide}, 32'h1);
    chk("R5 XTS not pass", {31'h0, selPass}, 32'h0);
    chk("R3 offset r3", {12'h0, selOffset}, 32'h000F_FFFF);
    chk("R4 key1 word0", selKey1[31:0], 32'hA5A5_A5A5);
    chk("R4 key2 word7", selKey2[255:224], 32'h5A5A_0001);
    chk("R4 key1 word1 zero", selKey1[63:32], 32'h0);
    pick(3'd0);
    chk("R5 bypass pass", {31'h0, selPass}, 32'h1);
    chk("R6 bypass bit r0", {31'h0, selBypass}, 32'h1);
    pick(3'd7);
    chk("R5 keystream not pass", {31'h0, selPass}, 32'h0);
    doWrite(9'h1E0, 32'h0000_0005);
    chk("R5 reserved mode pass", {31'h0, selPass}, 32'h1);
    doWrite(9'h1E0, 32'h0000_0003);
    chk("R5 ctr plain not pass", {31'h0, selPass}, 32'h0);

    // R7 lock sticky
    doWrite(9'h000, 32'h0000_0008);
    doRead(9'h000, rv); chk("R7 lock set", rv, 32'h8);
    doWrite(9'h000, 32'h0000_0000);
    doRead(9'h000, rv); chk("R7 lock kept", rv, 32'h8);

    // R8 locked writes ignored with error pulse
    doWrite(9'h160, 32'h0000_0003);
    chk("R8 err pulse", {31'h0, wrErr}, 32'h1);
    doRead(9'h160, rv); chk("R8 attr unchanged", rv, 32'h11);
    @(negedge clk);
    chk("R8 err one cycle", {31'h0, wrErr}, 32'h0);
    doWrite(9'h168, 32'h1234_5678);
    pick(3'd3);
    chk("R8 key unchanged", selKey1[31:0], 32'hA5A5_A5A5);
    doWrite(9'h161, 32'h0000_0001);
    chk("R8 offset unchanged", {12'h0, selOffset}, 32'h000F_FFFF);

    // R10 unlocked neighbour
    doWrite(9'h180, 32'h0000_0001);
    chk("R10 no err r4", {31'h0, wrErr}, 32'h0);
    doRead(9'h180, rv); chk("R10 r4 attr", rv, 32'h1);

    // R9 soft reset together with lock of r4
    doWrite(9'h000, 32'h8000_0010);
    doRead(9'h000, rv); chk("R9 srst visible", rv, 32'h8000_0018);
    pick(3'd0);
    chk("R9 not yet wiped", {31'h0, selBypass}, 32'h1);
    @(negedge clk);
    doRead(9'h000, rv); chk("R9 srst cleared locks kept", rv, 32'h18);
    doRead(9'h160, rv); chk("R9 attr wiped", rv, 32'h0);
    pick(3'd3);
    chk("R9 key wiped", {31'h0, (selKey1 == '0 && selKey2 == '0)}, 32'h1);
    chk("R9 offset kept r3", {12'h0, selOffset}, 32'h000F_FFFF);
    doRead(9'h1A1, rv); chk("R9 offset kept r5", rv, 32'h0001_2345);
    doWrite(9'h180, 32'h0000_0002);
    chk("R9 new lock active", {31'h0, wrErr}, 32'h1);

    // R7 only system reset clears locks
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doRead(9'h000, rv); chk("R7 locks cleared", rv, 32'h0);
    doWrite(9'h160, 32'h0000_0002);
    doRead(9'h160, rv); chk("R7 write after unlock", rv, 32'h2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule